// File: doc/BRIEF.md
# Bidirectional Port with Analog Pin Takeover and Key Wake

An eight-pin general-purpose port on a small register bus. Each pin has a direction bit and an output latch bit. The bus can read back a value that is built per bit: an input-mode bit gives the synchronized pad level, and an output-mode bit gives the latch. A converter control pair hands one pin to an analog input. The pair is a binary channel select and an active-low analog-disable bit. While analog is enabled, the chosen pin stops driving and reads as zero, whatever its direction and latch bits hold. The other pins keep their normal digital behaviour.

The upper four pins also act as key wake-up sources while the system is stopped. A small state machine watches them through the same two-stage pad synchronizer used for readback. It has three states:

- WK_IDLE: the system is running. The machine moves to WK_ARMED when `stop_req` rises.
- WK_ARMED: the machine watches the key pins. It moves to WK_FIRED when an eligible key pin is low. It returns to WK_IDLE if `stop_req` falls first.
- WK_FIRED: `wake_o` is high. The machine returns to WK_IDLE once `stop_req` falls.

A key pin is eligible when it is in input mode and is not the active analog channel.

A bit-manipulation sequence in software (read, change one bit, write back) stores the mixed readback value. As a result, latch bits that belong to input-mode pins take on the pin levels.

Top module: `gpio_ana_port`

## Requirements
- R1: After reset, the direction register and the output latch are all zero, no pad output enable is asserted, `wake_o` is low, and a data read returns the pad levels.
- R2: Bit i of `pad_oe` is 1 exactly when direction bit i is 1 (1 = output, 0 = input) and pin i is not the active analog channel.
- R3: A bus write to the data register at address 0x03 updates every latch bit, whatever the direction bits hold. `pad_out` always shows the latch.
- R4: A read of address 0x03 returns, bit by bit, the synchronized pad level for input-mode bits and the latch value for output-mode bits.
- R5: While `ana_dis` is 0, the pin whose index equals the binary value of `ana_sel` has `pad_oe` low and reads as 0 from address 0x03.
- R6: While `ana_dis` is 0, pins other than the selected one keep their R2 and R4 behaviour. While `ana_dis` is 1, no pin is overridden.
- R7: The direction register sits at address 0x0E and reads back as written. A write to any other address changes neither register, and a read of any other address returns 0.
- R8: While `stop_req` is high, a low level on an eligible pin among pins 7 to 4 sets `wake_o` high within three clock edges. `wake_o` then stays high until `stop_req` falls.
- R9: A low level on a key pin in output mode, on the active analog pin, on pins 3 to 0, or while `stop_req` is low does not assert `wake_o`.
- R10: A read-modify-write of the data register writes the mixed readback value into the latch, so input-mode latch bits take the pin levels.
- R11: A pad change is not visible on a data read one clock edge later. It is visible two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, zero when not reading) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enables |
| ana_sel | input | 3 | Analog channel index |
| ana_dis | input | 1 | 1 = analog off, 0 = selected pin is analog |
| stop_req | input | 1 | System stop indication |
| wake_o | output | 1 | Key wake-up request |

## Verification
A corrupted direction or latch bit appears at `pad_oe` or `pad_out` in the same cycle. It also appears on the next data read, so the random sweeps compare all three against a bench model after every register setup. A wrong synchronizer depth or a wrong readback mux shows up on a read two edges after a pad change. A wake machine stuck in the wrong state shows up at `wake_o` within three edges of a key-pin change or a `stop_req` change. The directed cases therefore sample at exactly those edges.

// File: rtl/gpio_ana_pkg.sv
package gpio_ana_pkg;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ARMED = 2'd1,
        WK_FIRED = 2'd2
    } wake_st_t;

endpackage

// File: rtl/gpio_ana_sync.sv
module gpio_ana_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = STAGES * W;

    logic [CW-1:0] chain_q;

    // reset to all ones so an idle pad does not look like a key press
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CW-W-1:0], d};
    end

    assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/gpio_ana_amask.sv
module gpio_ana_amask #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic [SEL_W-1:0] ana_sel,
    input  logic             ana_dis,
    output logic [W-1:0]     mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = !ana_dis && (ana_sel == SEL_W'(i));
    end
endmodule

// File: rtl/gpio_ana_regs.sv
module gpio_ana_regs #(
    parameter int             W         = 8,
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  DATA_ADDR = 8'h03,
    parameter logic [AW-1:0]  DIR_ADDR  = 8'h0E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_sync,
    input  logic [W-1:0]  ana_mask,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  bus_rdata
);
    logic          wr_data, wr_dir;
    logic [W-1:0]  mixed;

    assign wr_data = bus_sel && bus_we && (bus_addr == DATA_ADDR);
    assign wr_dir  = bus_sel && bus_we && (bus_addr == DIR_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (wr_data) latch_q <= bus_wdata;
            if (wr_dir)  dir_q   <= bus_wdata;
        end
    end

    // per-bit readback: latch for outputs, pin for inputs, zero for analog
    assign mixed = ((dir_q & latch_q) | (~dir_q & pin_sync)) & ~ana_mask;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == DATA_ADDR)     bus_rdata = mixed;
            else if (bus_addr == DIR_ADDR) bus_rdata = dir_q;
        end
    end
endmodule

// File: rtl/gpio_ana_wake.sv
module gpio_ana_wake
    import gpio_ana_pkg::*;
#(
    parameter int KEY_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [KEY_N-1:0] key_lvl,
    input  logic [KEY_N-1:0] key_dir,
    input  logic [KEY_N-1:0] key_ana,
    output logic             wake_o
);
    wake_st_t state_q, state_d;
    logic     key_hit;

    assign key_hit = |(~key_lvl & ~key_dir & ~key_ana);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:  if (stop_req) state_d = WK_ARMED;
            WK_ARMED: begin
                if (!stop_req)    state_d = WK_IDLE;
                else if (key_hit) state_d = WK_FIRED;
            end
            WK_FIRED: if (!stop_req) state_d = WK_IDLE;
            default:  state_d = WK_IDLE;
        endcase
    end

    always_comb begin
        wake_o = (state_q == WK_FIRED);
    end
endmodule

// File: rtl/gpio_ana_port.sv
module gpio_ana_port #(
    parameter int            W           = 8,
    parameter int            AW          = 8,
    parameter int            SEL_W       = $clog2(W),
    parameter logic [AW-1:0] DATA_ADDR   = 8'h03,
    parameter logic [AW-1:0] DIR_ADDR    = 8'h0E,
    parameter int            KEY_N       = 4,
    parameter int            SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    input  logic [SEL_W-1:0] ana_sel,
    input  logic             ana_dis,
    input  logic             stop_req,
    output logic             wake_o
);
    localparam int KEY_LSB = W - KEY_N;

    logic [W-1:0] pin_sync, ana_mask, latch_q, dir_q;

    gpio_ana_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_ana_amask #(.W(W), .SEL_W(SEL_W)) amask_i (
        .ana_sel(ana_sel), .ana_dis(ana_dis), .mask(ana_mask)
    );

    gpio_ana_regs #(.W(W), .AW(AW), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_sync(pin_sync),
        .ana_mask(ana_mask), .latch_q(latch_q), .dir_q(dir_q), .bus_rdata(bus_rdata)
    );

    gpio_ana_wake #(.KEY_N(KEY_N)) wake_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .key_lvl(pin_sync[KEY_LSB +: KEY_N]),
        .key_dir(dir_q[KEY_LSB +: KEY_N]),
        .key_ana(ana_mask[KEY_LSB +: KEY_N]),
        .wake_o(wake_o)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q & ~ana_mask;
endmodule

// File: rtl/gpio_ana_port_chk.sv
module gpio_ana_port_chk #(
    parameter int            W         = 8,
    parameter int            AW        = 8,
    parameter int            SEL_W     = $clog2(W),
    parameter logic [AW-1:0] DATA_ADDR = 8'h03
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     bus_rdata,
    input logic [W-1:0]     pad_oe,
    input logic [SEL_W-1:0] ana_sel,
    input logic             ana_dis,
    input logic             stop_req,
    input logic             wake_o,
    input logic [W-1:0]     latch_q,
    input logic [W-1:0]     dir_q
);
    p_oe_needs_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    p_ana_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ana_dis |-> !pad_oe[ana_sel]);

    p_ana_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == DATA_ADDR && !ana_dis) |-> !bus_rdata[ana_sel]);

    p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == DATA_ADDR) |=> (latch_q == $past(bus_wdata)));

    p_wake_needs_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && !$past(stop_req)) |-> !wake_o);
endmodule

bind gpio_ana_port gpio_ana_port_chk #(
    .W(W), .AW(AW), .SEL_W(SEL_W), .DATA_ADDR(DATA_ADDR)
) chk_i (.*);

// File: tb/gpio_ana_port_tb_top.sv
module gpio_ana_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_out, pad_oe;
    logic [2:0] ana_sel = '0;
    logic       ana_dis = 1'b1;
    logic       stop_req = 1'b0;
    logic       wake_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_ana_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .ana_sel(ana_sel), .ana_dis(ana_dis), .stop_req(stop_req), .wake_o(wake_o)
    );

    function automatic logic [7:0] amask(input logic dis, input logic [2:0] sel);
        return dis ? 8'h00 : (8'h01 << sel);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] d, input logic [7:0] l,
                                            input logic [7:0] p, input logic [7:0] m);
        return ((d & l) | (~d & p)) & ~m;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        settle(3);
        rst_n = 1'b1;
        pad_in = 8'hA5;
        settle(3);

        // R1: reset state
        rd(8'h0E, v); chk("R1 dir", v, 8'h00);
        rd(8'h03, v); chk("R1 read", v, 8'hA5);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 out", pad_out, 8'h00);
        chk("R1 wake", {7'd0, wake_o}, 8'h00);

        // R3: latch loads in input mode, then shows on output switch
        wr(8'h03, 8'h3C);
        chk("R3 latch in input mode", pad_out, 8'h3C);
        rd(8'h03, v); chk("R4 input reads pin", v, 8'hA5);
        wr(8'h0E, 8'hFF);
        rd(8'h03, v); chk("R4 output reads latch", v, 8'h3C);
        chk("R2 oe all", pad_oe, 8'hFF);

        // R7: other address ignored
        wr(8'h05, 8'h00);
        rd(8'h0E, v); chk("R7 dir kept", v, 8'hFF);
        chk("R7 latch kept", pad_out, 8'h3C);
        rd(8'h05, v); chk("R7 unmapped read", v, 8'h00);

        // R10: read-modify-write copies pin levels into input-mode latch bits
        wr(8'h03, 8'h00);
        wr(8'h0E, 8'h0F);
        pad_in = 8'hF0;
        settle(3);
        rd(8'h03, v); chk("R10 mixed read", v, 8'hF0);
        wr(8'h03, v | 8'h01);
        wr(8'h0E, 8'hFF);
        rd(8'h03, v); chk("R10 latch after rmw", v, 8'hF1);

        // R11: two-stage pad synchronizer
        wr(8'h0E, 8'h00);
        pad_in = 8'h00;
        settle(3);
        pad_in = 8'hFF;
        rd(8'h03, v); chk("R11 one edge", v, 8'h00);
        rd(8'h03, v); chk("R11 two edges", v, 8'hFF);

        // R5/R6: analog override
        wr(8'h03, 8'hFF);
        wr(8'h0E, 8'hFF);
        ana_sel = 3'd2; ana_dis = 1'b0;
        settle(1);
        chk("R5 oe off", pad_oe, 8'hFB);
        rd(8'h03, v); chk("R5 read zero", v, 8'hFB);
        ana_dis = 1'b1;
        settle(1);
        chk("R6 no override", pad_oe, 8'hFF);

        // R8: wake on key pin
        wr(8'h0E, 8'h00);
        pad_in = 8'hFF; stop_req = 1'b1;
        settle(3);
        chk("R8 no key", {7'd0, wake_o}, 8'h00);
        pad_in = 8'hBF;
        settle(3);
        chk("R8 wake", {7'd0, wake_o}, 8'h01);
        pad_in = 8'hFF;
        settle(3);
        chk("R8 held", {7'd0, wake_o}, 8'h01);
        stop_req = 1'b0;
        settle(2);
        chk("R8 cleared", {7'd0, wake_o}, 8'h00);

        // R9: ineligible sources
        stop_req = 1'b1;
        wr(8'h0E, 8'h40);
        pad_in = 8'hBF;
        settle(4);
        chk("R9 output-mode key", {7'd0, wake_o}, 8'h00);
        wr(8'h0E, 8'h00);
        ana_sel = 3'd6; ana_dis = 1'b0;
        settle(4);
        chk("R9 analog key", {7'd0, wake_o}, 8'h00);
        pad_in = 8'hF7;
        settle(4);
        chk("R9 low pin3", {7'd0, wake_o}, 8'h00);
        ana_dis = 1'b1; pad_in = 8'hFF;
        stop_req = 1'b0;
        settle(2);
        pad_in = 8'h0F;
        settle(4);
        chk("R9 not stopped", {7'd0, wake_o}, 8'h00);
        stop_req = 1'b1;
        settle(3);
        chk("R8 stop after press", {7'd0, wake_o}, 8'h01);
        stop_req = 1'b0;
        settle(2);

        // random sweep: R2, R3, R4, R5, R6
        for (int it = 0; it < 60; it++) begin
            logic [7:0] d, l, p, m;
            d = 8'($urandom); l = 8'($urandom); p = 8'($urandom);
            ana_dis = 1'($urandom); ana_sel = 3'($urandom);
            m = amask(ana_dis, ana_sel);
            wr(8'h03, l);
            wr(8'h0E, d);
            pad_in = p;
            settle(3);
            rd(8'h03, v);
            chk("R4 R5 R6 random read", v, exp_read(d, l, p, m));
            chk("R2 R5 random oe", pad_oe, d & ~m);
            chk("R3 random out", pad_out, l);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule